// File: doc/BRIEF.md
# Two-Bank Register File with Shared Cross Operand

This block holds the general-purpose registers of a two-sided execution core. There are two banks, side A and side B. Each bank has thirty-two 32-bit registers, so the core has 64 registers in all. Four execution units sit on each side. Each unit has two local read ports and one write port into its own side's bank. A unit may take its second operand from the side's single cross operand instead of its second local port. The cross operand is one register read from the opposite bank per cycle, and up to two units of the requesting side may share it.

Reads are combinational from the stored state and always return the value held before the clock edge, so a write never bypasses into a read of the same cycle. Writes take effect at the next rising clock edge. In the same cycle the block raises a per-side conflict flag whenever the request set of that side breaks a rule:
- too many local reads of one register;
- cross-operand requests that cannot be met;
- two writes to one register.

Top module: `dual_rf`

## Requirements
- R1: A synchronous reset (active-high `rst`) clears all 64 registers to zero. In the first cycle after reset every read returns zero.
- R2: Unit t (units 0..3 are side A and use bank A; units 4..7 are side B and use bank B) returns on `op1_data` its bank's register at `rd1_addr`. When `xsel[t]` is 0 it returns on `op2_data` its bank's register at `rd2_addr`. Both values are presented combinationally.
- R3: When `wr_en[t]` is 1, `wr_data` is stored into the unit's own bank at `wr_addr` at the rising edge and is readable from the next cycle. A read of that register in the write cycle returns the old value.
- R4: When `xsel[t]` is 1, `op2_data` of unit t is the register at `xaddr` in the opposite bank, unless that side has a cross-path clash.
- R5: Two units of one side that select the cross operand with the same `xaddr` both receive that value, and the cross path raises no conflict.
- R6: If selecting units of one side name different `xaddr` values, that side's `conflict` bit is 1 and every selecting unit of that side receives zero on `op2_data`.
- R7: If more than two units of one side select the cross operand, that side's `conflict` bit is 1 and every selecting unit of that side receives zero on `op2_data`.
- R8: A side's `conflict` bit is 1 when more than four enabled local reads of that side address one register. A local read is `rd1_en`, or `rd2_en` with `xsel` 0. Cross-path reads from the other side are never counted. Read data is still returned.
- R9: If two units of one side write the same register in one cycle, that side's `conflict` bit is 1 and the lowest-numbered unit's data is stored.
- R10: `conflict[0]` covers side A and `conflict[1]` covers side B. Each bit is combinational from the current cycle's requests and is 0 when the side's requests break no rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd1_en | input | 8 | Per-unit enable of the first local read (counted for R8) |
| rd1_addr | input | 40 | Per-unit first read address, 5 bits per unit |
| rd2_en | input | 8 | Per-unit enable of the second local read |
| rd2_addr | input | 40 | Per-unit second read address |
| xsel | input | 8 | Per-unit select of the cross operand as second operand |
| xaddr | input | 40 | Per-unit cross register address in the opposite bank |
| wr_en | input | 8 | Per-unit write enable |
| wr_addr | input | 40 | Per-unit write address |
| wr_data | input | 256 | Per-unit write data, 32 bits per unit |
| op1_data | output | 256 | Per-unit first operand |
| op2_data | output | 256 | Per-unit second operand, local or cross |
| conflict | output | 2 | Per-side rule violation flag, bit 0 side A |

## Verification
Two functions can fall in the same cycle and interact:
- the register-pressure count on one bank;
- the other side's cross read of that same register.

The bench drives four local reads of one register on side A while side B pulls the same register across. It expects no conflict, because cross reads must not be counted. It then adds a fifth local read and expects the flag. A write and a read of the same register also share a cycle in the fill phase. There the reference model expects the old value, and the new value one cycle later.

// File: rtl/dual_rf_pkg.sv
package dual_rf_pkg;

    localparam int SIDES = 2;

    // index of the bank that feeds a side's cross operand
    function automatic int far_side(input int s);
        return SIDES - 1 - s;
    endfunction

endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int NUM_REGS = 32,
    parameter int DW       = 32,
    parameter int NU       = 4,
    parameter int RP       = 9,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NU-1:0]      wr_en,
    input  logic [NU*AW-1:0]   wr_addr,
    input  logic [NU*DW-1:0]   wr_data,
    input  logic [RP*AW-1:0]   rd_addr,
    output logic [RP*DW-1:0]   rd_data,
    output logic               wr_clash
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DW-1:0] regs;
    } bank_t;

    bank_t bank_d, bank_q;

    // next state: highest unit applied first so unit 0 lands last and wins
    always_comb begin
        bank_d = bank_q;
        if (rst) begin
            bank_d = '0;
        end else begin
            for (int u = NU - 1; u >= 0; u--) begin
                if (wr_en[u]) begin
                    bank_d.regs[wr_addr[u*AW +: AW]] = wr_data[u*DW +: DW];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    // same-cycle duplicate write detection
    always_comb begin
        wr_clash = 1'b0;
        for (int i = 0; i < NU; i++) begin
            for (int j = i + 1; j < NU; j++) begin
                if (wr_en[i] && wr_en[j] &&
                    (wr_addr[i*AW +: AW] == wr_addr[j*AW +: AW])) begin
                    wr_clash = 1'b1;
                end
            end
        end
    end

    // combinational reads of the stored state: no write-through
    for (genvar p = 0; p < RP; p++) begin : g_rd
        assign rd_data[p*DW +: DW] = bank_q.regs[rd_addr[p*AW +: AW]];
    end

endmodule

// File: rtl/rf_xpath.sv
module rf_xpath #(
    parameter int NU     = 4,
    parameter int AW     = 5,
    parameter int FANOUT = 2,
    localparam int CW    = $clog2(NU + 1)
) (
    input  logic [NU-1:0]    xsel,
    input  logic [NU*AW-1:0] xaddr,
    output logic [AW-1:0]    far_addr,
    output logic             clash
);

    logic [CW-1:0] users;
    logic          found;
    logic          mismatch;

    always_comb begin
        users    = '0;
        found    = 1'b0;
        mismatch = 1'b0;
        far_addr = '0;
        for (int u = 0; u < NU; u++) begin
            if (xsel[u]) begin
                if (!found) begin
                    far_addr = xaddr[u*AW +: AW];
                    found    = 1'b1;
                end else if (xaddr[u*AW +: AW] != far_addr) begin
                    mismatch = 1'b1;
                end
                users = users + CW'(1);
            end
        end
        clash = mismatch || (int'(users) > FANOUT);
    end

endmodule

// File: rtl/rf_read_limit.sv
module rf_read_limit #(
    parameter int NP    = 8,
    parameter int AW    = 5,
    parameter int LIMIT = 4,
    localparam int CW   = $clog2(NP + 1)
) (
    input  logic [NP-1:0]    en,
    input  logic [NP*AW-1:0] addr,
    output logic             over
);

    logic [CW-1:0] hits;

    // pairwise count: each enabled port counts the ports sharing its address
    always_comb begin
        over = 1'b0;
        hits = '0;
        for (int i = 0; i < NP; i++) begin
            hits = '0;
            for (int j = 0; j < NP; j++) begin
                if (en[i] && en[j] &&
                    (addr[i*AW +: AW] == addr[j*AW +: AW])) begin
                    hits = hits + CW'(1);
                end
            end
            if (int'(hits) > LIMIT) begin
                over = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dual_rf.sv
module dual_rf
    import dual_rf_pkg::*;
#(
    parameter int NUM_REGS   = 32,
    parameter int DW         = 32,
    parameter int NU         = 4,
    parameter int XP_FANOUT  = 2,
    parameter int READ_LIMIT = 4,
    localparam int AW        = $clog2(NUM_REGS),
    localparam int NT        = SIDES * NU,
    localparam int RP        = 2 * NU + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NT-1:0]    rd1_en,
    input  logic [NT*AW-1:0] rd1_addr,
    input  logic [NT-1:0]    rd2_en,
    input  logic [NT*AW-1:0] rd2_addr,
    input  logic [NT-1:0]    xsel,
    input  logic [NT*AW-1:0] xaddr,
    input  logic [NT-1:0]    wr_en,
    input  logic [NT*AW-1:0] wr_addr,
    input  logic [NT*DW-1:0] wr_data,
    output logic [NT*DW-1:0] op1_data,
    output logic [NT*DW-1:0] op2_data,
    output logic [SIDES-1:0] conflict
);

    logic [RP*AW-1:0]   bank_ra  [SIDES];
    logic [RP*DW-1:0]   bank_rd  [SIDES];
    logic [2*NU-1:0]    local_en [SIDES];
    logic [AW-1:0]      far_ra   [SIDES];
    logic [DW-1:0]      far_data [SIDES];
    logic [SIDES-1:0]   xp_clash;
    logic [SIDES-1:0]   rd_over;
    logic [SIDES-1:0]   wr_clash;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int FS = far_side(s);

        for (genvar u = 0; u < NU; u++) begin : g_unit
            localparam int T = s * NU + u;

            assign bank_ra[s][2*u*AW +: AW]     = rd1_addr[T*AW +: AW];
            assign bank_ra[s][(2*u+1)*AW +: AW] = rd2_addr[T*AW +: AW];
            assign local_en[s][2*u]             = rd1_en[T];
            assign local_en[s][2*u+1]           = rd2_en[T] & ~xsel[T];

            assign op1_data[T*DW +: DW] = bank_rd[s][2*u*DW +: DW];
            assign op2_data[T*DW +: DW] = xsel[T]
                                        ? (xp_clash[s] ? '0 : far_data[s])
                                        : bank_rd[s][(2*u+1)*DW +: DW];
        end

        // last read port of this bank serves the other side's cross operand
        assign bank_ra[s][2*NU*AW +: AW] = far_ra[FS];
        assign far_data[s]               = bank_rd[FS][2*NU*DW +: DW];

        rf_bank #(
            .NUM_REGS (NUM_REGS),
            .DW       (DW),
            .NU       (NU),
            .RP       (RP)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en[s*NU +: NU]),
            .wr_addr  (wr_addr[s*NU*AW +: NU*AW]),
            .wr_data  (wr_data[s*NU*DW +: NU*DW]),
            .rd_addr  (bank_ra[s]),
            .rd_data  (bank_rd[s]),
            .wr_clash (wr_clash[s])
        );

        rf_xpath #(
            .NU       (NU),
            .AW       (AW),
            .FANOUT   (XP_FANOUT)
        ) u_xpath (
            .xsel     (xsel[s*NU +: NU]),
            .xaddr    (xaddr[s*NU*AW +: NU*AW]),
            .far_addr (far_ra[s]),
            .clash    (xp_clash[s])
        );

        rf_read_limit #(
            .NP       (2 * NU),
            .AW       (AW),
            .LIMIT    (READ_LIMIT)
        ) u_limit (
            .en       (local_en[s]),
            .addr     (bank_ra[s][2*NU*AW-1:0]),
            .over     (rd_over[s])
        );

        assign conflict[s] = xp_clash[s] | rd_over[s] | wr_clash[s];
    end

endmodule

// File: rtl/dual_rf_chk.sv
module dual_rf_chk #(
    parameter int NUM_REGS  = 32,
    parameter int DW        = 32,
    parameter int NU        = 4,
    parameter int XP_FANOUT = 2,
    localparam int AW       = $clog2(NUM_REGS),
    localparam int NT       = 2 * NU
) (
    input logic             clk,
    input logic             rst,
    input logic [NT*AW-1:0] rd1_addr,
    input logic [NT-1:0]    xsel,
    input logic [NT*AW-1:0] xaddr,
    input logic [NT-1:0]    wr_en,
    input logic [NT*AW-1:0] wr_addr,
    input logic [NT*DW-1:0] wr_data,
    input logic [NT*DW-1:0] op1_data,
    input logic [NT*DW-1:0] op2_data,
    input logic [1:0]       conflict
);

    logic started_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        (started_q === 1'b1) && $past(rst) |-> (op1_data == '0) && (op2_data == '0));

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (started_q === 1'b1) && !$past(rst) && $past(wr_en[0]) &&
        (rd1_addr[AW-1:0] == $past(wr_addr[AW-1:0]))
        |-> op1_data[DW-1:0] == $past(wr_data[DW-1:0]));

    assert_xp_share_R5: assert property (@(posedge clk) disable iff (rst)
        xsel[0] && xsel[1] && (xaddr[AW-1:0] == xaddr[2*AW-1:AW]) &&
        ($countones(xsel[NU-1:0]) <= XP_FANOUT)
        |-> op2_data[DW-1:0] == op2_data[2*DW-1:DW]);

    assert_xp_mismatch_R6: assert property (@(posedge clk) disable iff (rst)
        xsel[0] && xsel[1] && (xaddr[AW-1:0] != xaddr[2*AW-1:AW])
        |-> conflict[0] && (op2_data[2*DW-1:0] == '0));

    assert_xp_fanout_R7: assert property (@(posedge clk) disable iff (rst)
        ($countones(xsel[NU-1:0]) > XP_FANOUT) |-> conflict[0]);

    assert_wr_clash_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en[NU] && wr_en[NU+1] &&
        (wr_addr[NU*AW +: AW] == wr_addr[(NU+1)*AW +: AW]) |-> conflict[1]);

endmodule

bind dual_rf dual_rf_chk #(
    .NUM_REGS  (NUM_REGS),
    .DW        (DW),
    .NU        (NU),
    .XP_FANOUT (XP_FANOUT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd1_addr (rd1_addr),
    .xsel     (xsel),
    .xaddr    (xaddr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .op1_data (op1_data),
    .op2_data (op2_data),
    .conflict (conflict)
);

// File: tb/dual_rf_tb.sv
module dual_rf_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 32;
    localparam int DW = 32;
    localparam int NU = 4;
    localparam int NT = 8;
    localparam int AW = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NT-1:0]    rd1_en, rd2_en, xsel, wr_en;
    logic [NT*AW-1:0] rd1_addr, rd2_addr, xaddr, wr_addr;
    logic [NT*DW-1:0] wr_data;
    logic [NT*DW-1:0] op1_data, op2_data;
    logic [1:0]       conflict;

    logic [DW-1:0] mdl [2][NR];
    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_rf u_dut (
        .clk(clk), .rst(rst),
        .rd1_en(rd1_en), .rd1_addr(rd1_addr),
        .rd2_en(rd2_en), .rd2_addr(rd2_addr),
        .xsel(xsel), .xaddr(xaddr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .op1_data(op1_data), .op2_data(op2_data), .conflict(conflict)
    );

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // reference model of the read side and the conflict rules
    task automatic compare();
        for (int s = 0; s < 2; s++) begin
            int  cnt [NR];
            int  users = 0;
            int  first = -1;
            bit  mism = 0, over = 0, wcl = 0, xc;
            for (int r = 0; r < NR; r++) cnt[r] = 0;
            for (int u = 0; u < NU; u++) begin
                int t = s * NU + u;
                if (xsel[t]) begin
                    if (first < 0) first = int'(xaddr[t*AW +: AW]);
                    else if (int'(xaddr[t*AW +: AW]) != first) mism = 1;
                    users++;
                end
                if (rd1_en[t]) cnt[rd1_addr[t*AW +: AW]]++;
                if (rd2_en[t] && !xsel[t]) cnt[rd2_addr[t*AW +: AW]]++;
                for (int v = u + 1; v < NU; v++) begin
                    int w = s * NU + v;
                    if (wr_en[t] && wr_en[w] && wr_addr[t*AW +: AW] == wr_addr[w*AW +: AW]) wcl = 1;
                end
            end
            for (int r = 0; r < NR; r++) if (cnt[r] > 4) over = 1;
            xc = mism || (users > 2);
            chk($sformatf("conflict[%0d]", s), {31'b0, conflict[s]}, {31'b0, (xc || over || wcl)});
            for (int u = 0; u < NU; u++) begin
                int t = s * NU + u;
                logic [DW-1:0] e2;
                chk($sformatf("op1 unit %0d", t), op1_data[t*DW +: DW], mdl[s][rd1_addr[t*AW +: AW]]);
                if (xsel[t]) e2 = xc ? '0 : mdl[1-s][xaddr[t*AW +: AW]];
                else         e2 = mdl[s][rd2_addr[t*AW +: AW]];
                chk($sformatf("op2 unit %0d", t), op2_data[t*DW +: DW], e2);
            end
        end
    endtask

    task automatic update();
        if (rst) begin
            for (int s = 0; s < 2; s++) for (int r = 0; r < NR; r++) mdl[s][r] = '0;
        end else begin
            for (int t = NT - 1; t >= 0; t--) begin
                if (wr_en[t]) mdl[t / NU][wr_addr[t*AW +: AW]] = wr_data[t*DW +: DW];
            end
        end
    endtask

    task automatic cyc();
        #1;
        if (!rst) compare();
        @(posedge clk);
        update();
        @(negedge clk);
    endtask

    task automatic idle();
        rd1_en = '0; rd2_en = '0; xsel = '0; wr_en = '0;
        rd1_addr = '0; rd2_addr = '0; xaddr = '0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic rd(input int t, input int a1, input int a2);
        rd1_en[t] = 1'b1; rd2_en[t] = 1'b1;
        rd1_addr[t*AW +: AW] = AW'(a1);
        rd2_addr[t*AW +: AW] = AW'(a2);
    endtask

    task automatic xp(input int t, input int a);
        xsel[t] = 1'b1;
        xaddr[t*AW +: AW] = AW'(a);
    endtask

    task automatic wr(input int t, input int a, input logic [DW-1:0] d);
        wr_en[t] = 1'b1;
        wr_addr[t*AW +: AW] = AW'(a);
        wr_data[t*DW +: DW] = d;
    endtask

    task automatic rnd(input int amax, input int wprob, input int xprob);
        idle();
        for (int t = 0; t < NT; t++) begin
            rd1_en[t] = 1'($urandom_range(1, 0));
            rd2_en[t] = 1'($urandom_range(1, 0));
            rd1_addr[t*AW +: AW] = AW'($urandom_range(amax, 0));
            rd2_addr[t*AW +: AW] = AW'($urandom_range(amax, 0));
            xsel[t] = ($urandom_range(99, 0) < xprob);
            xaddr[t*AW +: AW] = AW'($urandom_range(amax, 0));
            wr_en[t] = ($urandom_range(99, 0) < wprob);
            wr_addr[t*AW +: AW] = AW'($urandom_range(amax, 0));
            wr_data[t*DW +: DW] = $urandom();
        end
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;

        // R1: everything reads zero after reset
        tag = "R1";
        repeat (2) begin rnd(31, 0, 30); cyc(); end

        // R3: fill every register, reading the written one in the same cycle
        tag = "R3";
        for (int a = 0; a < NR; a++) begin
            idle();
            for (int s = 0; s < 2; s++) begin
                int t = s * NU + (a % NU);
                wr(t, a, {8'(s + 1), 8'(a), 16'($urandom())});
                rd(t, a, (a + 1) % NR);
            end
            cyc();
        end
        idle();
        for (int t = 0; t < NT; t++) rd(t, (NR - 1 - t), t);
        cyc();

        // R2: plain local reads
        tag = "R2";
        repeat (20) begin rnd(31, 0, 0); cyc(); end

        // R4: one cross user per side
        tag = "R4";
        repeat (20) begin
            rnd(31, 0, 0);
            xp($urandom_range(3, 0), $urandom_range(31, 0));
            xp(4 + $urandom_range(3, 0), $urandom_range(31, 0));
            cyc();
        end

        // R5: two users share one cross register
        tag = "R5";
        repeat (10) begin
            int a = $urandom_range(31, 0);
            rnd(31, 0, 0);
            xp(0, a); xp(2, a); xp(5, a + 1); xp(7, a + 1);
            cyc();
        end

        // R6: two users disagree on the cross register
        tag = "R6";
        repeat (6) begin
            int a = $urandom_range(31, 0);
            rnd(31, 0, 0);
            xp(1, a); xp(3, a ^ 1);
            cyc();
        end

        // R7: three users exceed the fan-out
        tag = "R7";
        repeat (6) begin
            int a = $urandom_range(31, 0);
            rnd(31, 0, 0);
            xp(4, a); xp(5, a); xp(6, a);
            cyc();
        end

        // R8: cross reads of a register do not add to its local count
        tag = "R8";
        idle();
        rd(0, 7, 7); rd(1, 7, 7);
        xp(4, 7); xp(5, 7);
        cyc();
        idle();
        rd(0, 7, 7); rd(1, 7, 7); rd(2, 7, 3);
        cyc();
        idle();
        rd(0, 9, 9); rd(1, 9, 9); rd(2, 9, 9);
        xp(2, 4);
        cyc();

        // R9: duplicate write, lowest unit wins
        tag = "R9";
        idle();
        wr(4, 12, 32'hAAAA_0004); wr(6, 12, 32'hBBBB_0006);
        wr(1, 20, 32'hCCCC_0001); wr(3, 20, 32'hDDDD_0003);
        cyc();
        idle();
        rd(4, 12, 12); rd(1, 20, 20);
        cyc();

        // R10: mixed traffic on a narrow address range
        tag = "R10";
        repeat (1500) begin rnd(3, 40, 30); cyc(); end
        repeat (300) begin rnd(31, 30, 20); cyc(); end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired in phase %s", tag);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule